// File: doc/BRIEF.md
# Triggered Two-Channel Sample Acquisition Controller

This block sequences the acquisition side of a two-channel digital oscilloscope. It runs a multi-channel parallel ADC through one conversion per sample interval. Each conversion is a convert strobe, a wait on the busy handshake, and four byte reads that assemble one 16-bit sample for channel 1 and one for channel 2. The sampling loop runs all the time, so the trigger logic always sees fresh channel 1 data.

A capture starts in one of two ways. In forced mode, a press of a button starts the capture. In triggered mode, channel 1 must rise through a programmable signed level. Once a capture starts, a store flag is set and every following sample pair is written into a sample buffer, from address 0 upward. When the buffer is full, the controller drops the flag and waits for the next event. The buffer has a synchronous read port for a display engine.

Two probe outputs allow the timing to be measured on the bench. One marks the conversion-plus-readout window. The other marks the start of each sample interval.

Top module: `acq_ctrl`

## Requirements
- R1: While `rst` is high, every strobe, `wr_en`, `store_flag` and `mem_full` is low. After `rst` falls, `adc_reset` is high for exactly one cycle, and it is never high again. That pulse comes before the first `adc_convst`.
- R2: Each sample cycle proceeds in this order:
  - `adc_convst` is high for exactly one cycle.
  - The controller waits until `adc_busy` has been seen high and then low.
  - It issues exactly four consecutive one-cycle `adc_rd` strobes, none of them while `adc_busy` is high.
- R3: The four bytes of a sample cycle are taken from `adc_data`, in order, as channel 1 bits 15:8, channel 1 bits 7:0, channel 2 bits 15:8 and channel 2 bits 7:0. The assembled pair appears on `wr_ch1`/`wr_ch2` when it is written.
- R4: `probe_conv` is high from the `adc_convst` cycle through the fourth `adc_rd` cycle, and low in every other cycle.
- R5: `probe_tick` is high in the `adc_convst` cycle and in no other cycle.
- R6: `rate_sel` is 2'b00 in every cycle.
- R7: When `forced_mode` is 1, a one-cycle `force_btn` pulse starts a capture, provided `store_flag` is low. If the pulse falls in the `adc_convst` cycle of a sample, that sample is the first one stored.
- R8: When `forced_mode` is 0, a capture starts at the first sample whose channel 1 value is at or above `trig_level`, when the previous sample was below it. Both comparisons are two's complement. That sample is the first one stored. If no such upward crossing occurs, no capture starts.
- R9: A capture writes exactly one pair per sample cycle. The writes go to addresses 0, 1, 2 and so on. `wr_en` is high only while `store_flag` is high.
- R10: After DEPTH writes, `mem_full` goes high and stays high until the next capture starts. `store_flag` clears and no further write occurs. `wr_addr` then reads 0.
- R11: The pair at buffer address `rd_addr` appears on `rd_ch1`/`rd_ch2` one cycle after `rd_addr` is applied. The data persists after the capture ends.
- R12: In triggered mode `force_btn` has no effect. In forced mode a channel 1 crossing has no effect.
- R13: A conversion begins only in the cycle after a `sample_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| forced_mode | input | 1 | 1 selects forced start, 0 selects level-crossing start |
| force_btn | input | 1 | One-cycle start request in forced mode |
| trig_level | input | 2*BYTE_W | Signed trigger level for channel 1 |
| adc_busy | input | 1 | ADC conversion in progress |
| adc_data | input | BYTE_W | ADC byte-wide read bus |
| sample_tick | input | 1 | Sample interval timer rollover pulse |
| rd_addr | input | clog2(DEPTH) | Buffer read address |
| adc_reset | output | 1 | ADC reset pulse |
| adc_convst | output | 1 | ADC convert-start strobe |
| adc_rd | output | 1 | ADC byte read strobe |
| rate_sel | output | 2 | Sample-rate select, fixed at fastest |
| probe_conv | output | 1 | Conversion-plus-readout window probe |
| probe_tick | output | 1 | Sample-interval start probe |
| store_flag | output | 1 | Capture in progress |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | clog2(DEPTH) | Buffer address of the current write |
| wr_ch1 | output | 2*BYTE_W | Channel 1 sample being written |
| wr_ch2 | output | 2*BYTE_W | Channel 2 sample being written |
| mem_full | output | 1 | Buffer filled by the last capture |
| rd_ch1 | output | 2*BYTE_W | Channel 1 read data |
| rd_ch2 | output | 2*BYTE_W | Channel 2 read data |

## Verification
The assertions guard properties that hold cycle by cycle:
- the convert strobe lasting a single cycle;
- no read strobe while the ADC reports busy;
- the interval probe staying inside the conversion window;
- conversions starting only after a tick;
- no write without the store flag or past a full buffer.

The bench's scenarios are needed for the properties that span many cycles:
- which sample a forced press or an upward crossing makes the first one stored;
- the byte assembly order;
- the address sequence across a full capture;
- the sticky full state and buffer readback;
- the fact that the inactive start source is ignored.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_ADC_RST,
    ST_CLR,
    ST_WAIT_INT,
    ST_CONV,
    ST_BUSY_HI,
    ST_BUSY_LO,
    ST_RD1H,
    ST_RD1L,
    ST_RD2H,
    ST_RD2L,
    ST_EVAL
  } acq_state_t;

  typedef struct packed {
    logic       adc_reset;
    logic       convst;
    logic       rd;
    logic       probe_conv;
    logic       probe_tick;
    logic [1:0] rate_sel;
  } ctrl_word_t;

  localparam logic [1:0] RATE_FASTEST = 2'b00;

endpackage

// File: rtl/acq_trigger.sv
module acq_trigger #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_done,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] level,
  output logic         hit
);

  logic [W-1:0] prev_q;
  logic         prev_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (sample_done) begin
      prev_q     <= cur;
      prev_vld_q <= 1'b1;
    end
  end

  assign hit = prev_vld_q
             && ($signed(prev_q) < $signed(level))
             && ($signed(cur) >= $signed(level));

endmodule

// File: rtl/acq_sample_buf.sv
module acq_sample_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          start,
  input  logic [W-1:0]  din1,
  input  logic [W-1:0]  din2,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  dout1,
  output logic [W-1:0]  dout2,
  output logic [AW-1:0] waddr,
  output logic          full
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [2*W-1:0] mem [DEPTH];
  logic [2*W-1:0] rd_q;
  logic [AW-1:0]  waddr_q;
  logic           full_q;

  assign waddr = start ? '0 : waddr_q;

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= {din2, din1};
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr_q <= '0;
      full_q  <= 1'b0;
    end else if (wr) begin
      waddr_q <= waddr + 1'b1;
      full_q  <= (waddr == LAST);
    end
  end

  assign dout1 = rd_q[W-1:0];
  assign dout2 = rd_q[2*W-1:W];
  assign full  = full_q;

  AST_NO_WRITE_PAST_FULL: assert property (@(posedge clk) disable iff (rst)
    (full_q && !start) |-> !wr); // R10

endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       forced_mode,
  input  logic       force_btn,
  input  logic       adc_busy,
  input  logic       sample_tick,
  input  logic       mem_full,
  input  logic       trig_hit,
  output ctrl_word_t ctrl,
  output logic [1:0] byte_sel,
  output logic       wr_en,
  output logic       cap_start,
  output logic       sample_done,
  output logic       store_flag
);

  acq_state_t state_q, state_d;
  logic       store_q, force_req_q;
  logic       fire, start_d, wr_d, done_d;

  function automatic ctrl_word_t decode(acq_state_t s);
    ctrl_word_t w;
    w          = '0;
    w.rate_sel = RATE_FASTEST;
    case (s)
      ST_ADC_RST: w.adc_reset = 1'b1;
      ST_CONV: begin
        w.convst     = 1'b1;
        w.probe_conv = 1'b1;
        w.probe_tick = 1'b1;
      end
      ST_BUSY_HI, ST_BUSY_LO: w.probe_conv = 1'b1;
      ST_RD1H, ST_RD1L, ST_RD2H, ST_RD2L: begin
        w.rd         = 1'b1;
        w.probe_conv = 1'b1;
      end
      default: ;
    endcase
    return w;
  endfunction

  function automatic logic [1:0] sel_of(acq_state_t s);
    case (s)
      ST_RD1L: return 2'd1;
      ST_RD2H: return 2'd2;
      ST_RD2L: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PWRUP:    state_d = ST_ADC_RST;
      ST_ADC_RST:  state_d = ST_CLR;
      ST_CLR:      state_d = ST_WAIT_INT;
      ST_WAIT_INT: begin
        if (store_q && mem_full) state_d = ST_CLR;
        else if (sample_tick)    state_d = ST_CONV;
      end
      ST_CONV:     state_d = ST_BUSY_HI;
      ST_BUSY_HI:  if (adc_busy)  state_d = ST_BUSY_LO;
      ST_BUSY_LO:  if (!adc_busy) state_d = ST_RD1H;
      ST_RD1H:     state_d = ST_RD1L;
      ST_RD1L:     state_d = ST_RD2H;
      ST_RD2H:     state_d = ST_RD2L;
      ST_RD2L:     state_d = ST_EVAL;
      ST_EVAL:     state_d = ST_WAIT_INT;
      default:     state_d = ST_PWRUP;
    endcase
  end

  assign fire    = forced_mode ? force_req_q : trig_hit;
  assign done_d  = (state_q == ST_RD2L);
  assign start_d = done_d && !store_q && fire;
  assign wr_d    = done_d && (store_q || fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_PWRUP;
      ctrl        <= '0;
      byte_sel    <= '0;
      wr_en       <= 1'b0;
      cap_start   <= 1'b0;
      sample_done <= 1'b0;
    end else begin
      state_q     <= state_d;
      ctrl        <= decode(state_d);
      byte_sel    <= sel_of(state_d);
      wr_en       <= wr_d;
      cap_start   <= start_d;
      sample_done <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q     <= 1'b0;
      force_req_q <= 1'b0;
    end else begin
      if (start_d)                 store_q <= 1'b1;
      else if (state_q == ST_CLR)  store_q <= 1'b0;

      if (!forced_mode || start_d)     force_req_q <= 1'b0;
      else if (force_btn && !store_q)  force_req_q <= 1'b1;
    end
  end

  assign store_flag = store_q;

  AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ctrl.convst |=> !ctrl.convst); // R2
  AST_RD_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    ctrl.rd |-> !adc_busy); // R2
  AST_TICK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ctrl.probe_tick |-> ctrl.probe_conv); // R5
  AST_CONV_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.convst) |-> $past(sample_tick)); // R13

endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int DEPTH       = 1024,
  localparam int SAMPLE_W   = 2 * BYTE_W,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                forced_mode,
  input  logic                force_btn,
  input  logic [SAMPLE_W-1:0] trig_level,
  input  logic                adc_busy,
  input  logic [BYTE_W-1:0]   adc_data,
  input  logic                sample_tick,
  input  logic [AW-1:0]       rd_addr,
  output logic                adc_reset,
  output logic                adc_convst,
  output logic                adc_rd,
  output logic [1:0]          rate_sel,
  output logic                probe_conv,
  output logic                probe_tick,
  output logic                store_flag,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [SAMPLE_W-1:0] wr_ch1,
  output logic [SAMPLE_W-1:0] wr_ch2,
  output logic                mem_full,
  output logic [SAMPLE_W-1:0] rd_ch1,
  output logic [SAMPLE_W-1:0] rd_ch2
);

  ctrl_word_t          ctrl;
  logic [1:0]          byte_sel;
  logic                cap_start, sample_done, trig_hit, full;
  logic [SAMPLE_W-1:0] ch1_q, ch2_q;

  acq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .forced_mode (forced_mode),
    .force_btn   (force_btn),
    .adc_busy    (adc_busy),
    .sample_tick (sample_tick),
    .mem_full    (full),
    .trig_hit    (trig_hit),
    .ctrl        (ctrl),
    .byte_sel    (byte_sel),
    .wr_en       (wr_en),
    .cap_start   (cap_start),
    .sample_done (sample_done),
    .store_flag  (store_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ch1_q <= '0;
      ch2_q <= '0;
    end else if (ctrl.rd) begin
      case (byte_sel)
        2'd0:    ch1_q[SAMPLE_W-1 -: BYTE_W] <= adc_data;
        2'd1:    ch1_q[BYTE_W-1:0]           <= adc_data;
        2'd2:    ch2_q[SAMPLE_W-1 -: BYTE_W] <= adc_data;
        default: ch2_q[BYTE_W-1:0]           <= adc_data;
      endcase
    end
  end

  acq_trigger #(.W(SAMPLE_W)) u_trig (
    .clk         (clk),
    .rst         (rst),
    .sample_done (sample_done),
    .cur         (ch1_q),
    .level       (trig_level),
    .hit         (trig_hit)
  );

  acq_sample_buf #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_en),
    .start   (cap_start),
    .din1    (ch1_q),
    .din2    (ch2_q),
    .rd_addr (rd_addr),
    .dout1   (rd_ch1),
    .dout2   (rd_ch2),
    .waddr   (wr_addr),
    .full    (full)
  );

  assign adc_reset  = ctrl.adc_reset;
  assign adc_convst = ctrl.convst;
  assign adc_rd     = ctrl.rd;
  assign rate_sel   = ctrl.rate_sel;
  assign probe_conv = ctrl.probe_conv;
  assign probe_tick = ctrl.probe_tick;
  assign wr_ch1     = ch1_q;
  assign wr_ch2     = ch2_q;
  assign mem_full   = full;

  AST_WRITE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> store_flag); // R9

endmodule

// File: tb/sim_acq_ctrl.sv
module sim_acq_ctrl;
  localparam int BW = 8;
  localparam int SW = 16;
  localparam int DEPTH = 1024;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, forced_mode, force_btn, adc_busy, sample_tick;
  logic [SW-1:0] trig_level;
  logic [BW-1:0] adc_data;
  logic [AW-1:0] rd_addr;
  logic adc_reset, adc_convst, adc_rd, probe_conv, probe_tick, store_flag, wr_en, mem_full;
  logic [1:0] rate_sel;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_ch1, wr_ch2, rd_ch1, rd_ch2;

  acq_ctrl #(.BYTE_W(BW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .forced_mode(forced_mode), .force_btn(force_btn),
    .trig_level(trig_level), .adc_busy(adc_busy), .adc_data(adc_data),
    .sample_tick(sample_tick), .rd_addr(rd_addr), .adc_reset(adc_reset),
    .adc_convst(adc_convst), .adc_rd(adc_rd), .rate_sel(rate_sel),
    .probe_conv(probe_conv), .probe_tick(probe_tick), .store_flag(store_flag),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_ch1(wr_ch1), .wr_ch2(wr_ch2),
    .mem_full(mem_full), .rd_ch1(rd_ch1), .rd_ch2(rd_ch2)
  );

  int checks = 0, errors = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ch1_of(int n);
    return 16'(n * 1237);
  endfunction
  function automatic logic [15:0] ch2_of(int n);
    return 16'(n * 3) ^ 16'h5A3C;
  endfunction

  typedef struct { int idx; logic [15:0] c1; logic [15:0] c2; } item_t;
  item_t exp_q[$];

  // ADC and interval timer model; acts as the scoreboard driver
  int cur_idx = 0, rd_cnt = 0, busy_cnt = 0, tick_cnt = 0;
  logic [15:0] prev_c1;
  bit prev_ok = 0;
  int exp_start_idx = -1;
  string exp_tag = "R8";
  bit capturing = 0;

  assign adc_busy    = (busy_cnt != 0);
  assign sample_tick = (tick_cnt == 15);
  always_comb begin
    case (rd_cnt)
      0: adc_data = ch1_of(cur_idx)[15:8];
      1: adc_data = ch1_of(cur_idx)[7:0];
      2: adc_data = ch2_of(cur_idx)[15:8];
      default: adc_data = ch2_of(cur_idx)[7:0];
    endcase
  end

  always @(posedge clk) begin
    if (rst) begin
      cur_idx <= 0; rd_cnt <= 0; busy_cnt <= 0; tick_cnt <= 0;
    end else begin
      tick_cnt <= (tick_cnt + 1) % 16;
      if (adc_convst) begin
        item_t it;
        it.idx = cur_idx + 1;
        it.c1  = ch1_of(it.idx);
        it.c2  = ch2_of(it.idx);
        exp_q.push_back(it);
        if (prev_ok && !forced_mode && !capturing && exp_start_idx < 0 &&
            $signed(prev_c1) < $signed(trig_level) && $signed(it.c1) >= $signed(trig_level)) begin
          exp_start_idx = it.idx;
          exp_tag = "R8";
        end
        prev_c1 = it.c1;
        prev_ok = 1;
        cur_idx  <= cur_idx + 1;
        busy_cnt <= 3;
        rd_cnt   <= 0;
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (adc_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  // Monitor
  int wr_in_cap = 0, cap_count = 0, total_writes = 0;
  logic [15:0] log1 [DEPTH];
  logic [15:0] log2 [DEPTH];
  int rst_pulses = 0, convs = 0;
  int v_tick = 0, v_rate = 0, v_win = 0, v_seq = 0, v_int = 0, v_reset = 0;
  bit win = 0, last_rd = 0, busy_seen = 0, prev_tick = 0;
  int rd_n = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (adc_reset) rst_pulses++;
      if (probe_tick !== adc_convst) v_tick++;
      if (rate_sel !== 2'b00) v_rate++;
      if (adc_convst) begin
        if (rst_pulses != 1) v_reset++;
        if (convs > 0 && rd_n != 4) v_seq++;
        if (!prev_tick) v_int++;
        convs++;
        win = 1; rd_n = 0; busy_seen = 0;
      end
      if (adc_busy) busy_seen = 1;
      if (probe_conv !== win) v_win++;
      if (adc_rd) begin
        if (adc_busy) v_seq++;
        if (rd_n == 0 && !busy_seen) v_seq++;
        if (rd_n > 0 && !last_rd) v_seq++;
        rd_n++;
        if (rd_n == 4) win = 0;
        if (rd_n > 4) v_seq++;
      end
      last_rd = adc_rd;
      prev_tick = sample_tick;

      if (wr_en) begin
        item_t e;
        total_writes++;
        if (exp_q.size() == 0) begin
          check(0, "R9", "write without fresh sample", 0, 1);
        end else begin
          e = exp_q[$];
          exp_q.delete();
          if (wr_in_cap == 0) begin
            check(exp_start_idx >= 0 && e.idx == exp_start_idx, exp_tag,
                  "first stored sample index", e.idx, exp_start_idx);
            capturing = 1;
          end
          check(wr_ch1 === e.c1, "R3", "ch1 write data", wr_ch1, e.c1);
          check(wr_ch2 === e.c2, "R3", "ch2 write data", wr_ch2, e.c2);
        end
        check(wr_addr == AW'(wr_in_cap), "R9", "write address", wr_addr, wr_in_cap);
        if (wr_in_cap < DEPTH) begin
          log1[wr_in_cap] = wr_ch1;
          log2[wr_in_cap] = wr_ch2;
        end
        wr_in_cap++;
        if (wr_in_cap == DEPTH) begin
          cap_count++; wr_in_cap = 0; capturing = 0; exp_start_idx = -1;
        end
      end
    end
  end

  task automatic report();
    check(rst_pulses == 1, "R1", "adc_reset pulses", rst_pulses, 1);
    check(v_reset == 0, "R1", "convst before reset pulse", v_reset, 0);
    check(v_seq == 0, "R2", "sequence violations", v_seq, 0);
    check(v_win == 0, "R4", "probe_conv window violations", v_win, 0);
    check(v_tick == 0, "R5", "probe_tick violations", v_tick, 0);
    check(v_rate == 0, "R6", "rate_sel violations", v_rate, 0);
    check(v_int == 0, "R13", "conversion without tick", v_int, 0);
    check(convs > 100, "R2", "conversions seen", convs, 100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic readback(int a);
    rd_addr = AW'(a);
    @(negedge clk);
    check(rd_ch1 === log1[a], "R11", "rd_ch1", rd_ch1, log1[a]);
    check(rd_ch2 === log2[a], "R11", "rd_ch2", rd_ch2, log2[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int w0;
    rst = 1; forced_mode = 0; force_btn = 0; trig_level = 16'd1000; rd_addr = '0;
    repeat (3) @(negedge clk);
    check({adc_reset, adc_convst, adc_rd, wr_en, store_flag, mem_full, probe_conv, probe_tick} == 8'd0,
          "R1", "outputs in reset",
          {adc_reset, adc_convst, adc_rd, wr_en, store_flag, mem_full, probe_conv, probe_tick}, 0);
    rst = 0;

    // Triggered capture on upward crossing of level 1000 (R8)
    while (!capturing) @(negedge clk);
    forced_mode = 1;
    while (cap_count < 1) @(negedge clk);
    repeat (40) @(negedge clk);
    check(mem_full == 1'b1, "R10", "mem_full after capture", mem_full, 1);
    check(store_flag == 1'b0, "R10", "store_flag after capture", store_flag, 0);
    check(wr_addr == '0, "R10", "wr_addr after capture", wr_addr, 0);
    w0 = total_writes;
    repeat (400) @(negedge clk);
    check(total_writes == w0, "R12", "writes from crossings in forced mode", total_writes - w0, 0);
    check(mem_full == 1'b1, "R10", "mem_full held while idle", mem_full, 1);
    readback(0); readback(1); readback(517); readback(DEPTH - 1);

    // Forced capture, press in a convert cycle (R7)
    @(negedge clk);
    while (!adc_convst) @(negedge clk);
    exp_start_idx = cur_idx + 1;
    exp_tag = "R7";
    force_btn = 1;
    @(negedge clk);
    force_btn = 0;
    while (cap_count < 2) @(negedge clk);
    repeat (5) @(negedge clk);
    check(mem_full == 1'b1, "R10", "mem_full after forced capture", mem_full, 1);
    readback(0); readback(DEPTH - 1);

    // Triggered mode with an unreachable level; button must be ignored (R12, R8)
    trig_level = 16'h8000;
    forced_mode = 0;
    w0 = total_writes;
    for (int k = 0; k < 5; k++) begin
      repeat (37) @(negedge clk);
      force_btn = 1;
      @(negedge clk);
      force_btn = 0;
    end
    repeat (2000) @(negedge clk);
    check(total_writes == w0, "R12", "writes from button in triggered mode", total_writes - w0, 0);
    check(store_flag == 1'b0, "R8", "no capture without crossing", store_flag, 0);

    report();
    $finish;
  end
endmodule